// File: doc/BRIEF.md
# Per-Core Interrupt Wake Request Generator

This block sits between an interrupt distributor and a system power controller. The distributor sends wake messages over an AXI4-Stream slave port. Each message names a core and says whether the wake comes from an interrupt aimed at that core alone or from a shared 1-of-N interrupt that has picked that core. The block drives one level-sensitive wake request per core, and the power controller uses that level to bring a sleeping core back up.

The block does not know whether a core is powered. A request that has asserted therefore stays high through power-up. It drops only when software lets the core leave sleep: that core's sleep flag is low and its child-domain asleep status then falls. Wakes from 1-of-N interrupts pass only while a global enable input is high. A request may assert while a core is still powering down, and the power controller is expected to ignore it until power-down completes.

Top module: `wake_req_gen`

## Requirements
- R1: There is one `wake_req` bit per core, bit i for core i. A synchronous active-low reset clears every `wake_req` bit and all per-core history.
- R2: `s_tready` is held at 1, and a beat counts only in a cycle where `s_tvalid` is 1. A cycle with `s_tvalid` low changes no output.
- R3: A beat whose `s_tdata[8]` is 0 (targeted) sets `wake_req[s_tdata[7:0]]` on the clock edge that accepts the beat, so the bit is visible right after that edge.
- R4: A beat whose `s_tdata[8]` is 1 (1-of-N) sets the addressed bit only when `oneofn_en` is 1 in the accepting cycle. When `oneofn_en` is 0 the beat has no effect.
- R5: A beat whose index `s_tdata[7:0]` is at or above NUM_CORES is accepted and then discarded, and no `wake_req` bit changes.
- R6: Once set, a `wake_req` bit stays at 1 whatever `proc_sleep` and `kids_asleep` do, until the clear condition of R7 occurs.
- R7: Bit i clears on an edge where `kids_asleep[i]` was 1 at the previous edge, is 0 now, and `proc_sleep[i]` is 0.
- R8: A falling `kids_asleep[i]` while `proc_sleep[i]` is 1 does not clear bit i. A wake beat still sets bit i while `proc_sleep[i]` and `kids_asleep[i]` are 1.
- R9: When a set for core i and the clear condition for core i fall on the same edge, the bit ends at 1.
- R10: A set or clear for one core leaves every other core's bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Stream ready, held at 1 |
| s_tdata | input | IDX_W+1 | [IDX_W-1:0] core index, [IDX_W] wake type (0 targeted, 1 1-of-N) |
| oneofn_en | input | 1 | Global enable for 1-of-N wakes |
| proc_sleep | input | NUM_CORES | Per-core processor-sleep flag from software |
| kids_asleep | input | NUM_CORES | Per-core child-domain asleep status |
| wake_req | output | NUM_CORES | Per-core wake request to the power controller |

## Verification
The bench targets the two-step exit. A falling asleep status while sleep is still set must leave the request high, and a design that clears on any falling edge, or on the sleep flag alone, would drop it early. A set that meets a clear on the same edge must win, and a clear-dominant latch would lose a wake there. Indexes just past the core count and far beyond it are sent as well, along with 1-of-N beats with the enable low. A decoder that wraps or truncates the index, or ignores the enable, would raise a bit that should have stayed low.

// File: rtl/wake_pkg.sv
// Shared types for the wake request generator.
// Assumes the stream word holds the core index in its low bits and the wake type above them.
package wake_pkg;
    typedef enum logic {
        WAKE_TARGETED = 1'b0,
        WAKE_ONEOFN   = 1'b1
    } wake_kind_e;
endpackage

// File: rtl/wake_msg_decode.sv
// Decodes one accepted stream beat into per-core set strobes.
// It handles both wake kinds, applies the 1-of-N enable and drops indexes out of range.
// Assumes NUM_CORES <= 2**IDX_W. The output is combinational and is used in the same cycle.
module wake_msg_decode #(
    parameter int NUM_CORES = 8,
    parameter int IDX_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 beat_ok,
    input  logic [IDX_W:0]       beat_data,
    input  logic                 oneofn_en,
    output logic [NUM_CORES-1:0] set_vec
);
    import wake_pkg::*;

    localparam logic [IDX_W:0] CORE_LIM = (IDX_W+1)'(NUM_CORES);

    logic [IDX_W-1:0] idx;
    wake_kind_e       kind;
    logic             in_range;
    logic             kind_ok;

    // Split the beat into index and kind, and qualify it.
    always_comb begin
        idx      = beat_data[IDX_W-1:0];
        kind     = wake_kind_e'(beat_data[IDX_W]);
        in_range = ({1'b0, idx} < CORE_LIM);
        kind_ok  = (kind == WAKE_TARGETED) || oneofn_en;
    end

    // One strobe per core, raised only for the addressed core.
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_hit
        assign set_vec[i] = beat_ok && in_range && kind_ok && (idx == IDX_W'(i));
    end

    assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_vec));
    assert_range_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ok && ({1'b0, beat_data[IDX_W-1:0]} >= CORE_LIM)) |-> (set_vec == '0));
    assert_oneofn_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ok && beat_data[IDX_W] && !oneofn_en) |-> (set_vec == '0));
    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_ok |-> (set_vec == '0));
endmodule

// File: rtl/wake_core_cell.sv
// Holds the wake request of one core in a set-dominant latch.
// It clears only when the child-asleep status falls while the sleep flag is low.
// Assumes the status inputs are already synchronous to clk.
module wake_core_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic psleep_i,
    input  logic kids_i,
    output logic wake_o
);
    logic kids_prev;
    logic wake_q;
    logic exit_done;

    // The clear fires on a falling asleep status with sleep released.
    assign exit_done = kids_prev && !kids_i && !psleep_i;

    // Remember the asleep status of the last edge for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) kids_prev <= 1'b0;
        else        kids_prev <= kids_i;
    end

    // Set-dominant request latch.
    always_ff @(posedge clk) begin
        if (!rst_n)         wake_q <= 1'b0;
        else if (set_i)     wake_q <= 1'b1;
        else if (exit_done) wake_q <= 1'b0;
    end

    assign wake_o = wake_q;

    assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> wake_o);
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && exit_done) |=> wake_o);
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o && !set_i && !exit_done) |=> wake_o);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_o && !set_i) |=> !wake_o);
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_done && !set_i) |=> !wake_o);
    assert_sleep_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o && psleep_i) |=> wake_o);
endmodule

// File: rtl/wake_req_gen.sv
// Top of the per-core wake request generator.
// It takes wake messages from a stream slave that is always ready and drives one sticky
// wake level per core toward the power controller.
// Assumes all inputs are synchronous to clk and that NUM_CORES <= 2**IDX_W.
module wake_req_gen #(
    parameter int NUM_CORES = 8,
    parameter int IDX_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s_tvalid,
    output logic                 s_tready,
    input  logic [IDX_W:0]       s_tdata,
    input  logic                 oneofn_en,
    input  logic [NUM_CORES-1:0] proc_sleep,
    input  logic [NUM_CORES-1:0] kids_asleep,
    output logic [NUM_CORES-1:0] wake_req
);
    logic [NUM_CORES-1:0] set_vec;
    logic                 beat_ok;

    // The slave never stalls, so every valid beat is taken.
    assign s_tready = 1'b1;
    assign beat_ok  = s_tvalid && s_tready;

    wake_msg_decode #(
        .NUM_CORES(NUM_CORES),
        .IDX_W    (IDX_W)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat_ok  (beat_ok),
        .beat_data(s_tdata),
        .oneofn_en(oneofn_en),
        .set_vec  (set_vec)
    );

    // One latch cell per core.
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
        wake_core_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (set_vec[i]),
            .psleep_i(proc_sleep[i]),
            .kids_i  (kids_asleep[i]),
            .wake_o  (wake_req[i])
        );
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (wake_req == '0));
    assert_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_tvalid |-> s_tready);
endmodule

// File: tb/sim_wake_req_gen.sv
module sim_wake_req_gen;
    localparam int NC = 8;
    localparam int IW = 8;
    localparam int NV = 21;

    // Row: {valid, kind, idx[7:0], en, psleep[7:0], kids[7:0], expected wake[7:0]}
    localparam logic [34:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'd2,   1'b0, 8'h00, 8'h00, 8'h04}, // R3 targeted core 2
        {1'b1, 1'b1, 8'd5,   1'b0, 8'h00, 8'h00, 8'h04}, // R4 1-of-N, enable low
        {1'b1, 1'b1, 8'd5,   1'b1, 8'h00, 8'h00, 8'h24}, // R4 1-of-N, enable high
        {1'b0, 1'b0, 8'd0,   1'b0, 8'h00, 8'h00, 8'h24}, // R2 not valid
        {1'b1, 1'b0, 8'd8,   1'b0, 8'h00, 8'h00, 8'h24}, // R5 index just past range
        {1'b1, 1'b0, 8'd200, 1'b1, 8'h00, 8'h00, 8'h24}, // R5 index far past range
        {1'b0, 1'b0, 8'd0,   1'b0, 8'h04, 8'h04, 8'h24}, // R6 asleep rises
        {1'b0, 1'b0, 8'd0,   1'b0, 8'h04, 8'h00, 8'h24}, // R8 falls with sleep set
        {1'b0, 1'b0, 8'd0,   1'b0, 8'h00, 8'h04, 8'h24}, // R6 rises again
        {1'b0, 1'b0, 8'd0,   1'b0, 8'h00, 8'h00, 8'h20}, // R7 clear core 2, R10 core 5 kept
        {1'b0, 1'b0, 8'd0,   1'b0, 8'h00, 8'h20, 8'h20}, // R6
        {1'b1, 1'b0, 8'd5,   1'b0, 8'h00, 8'h00, 8'h20}, // R9 set meets clear
        {1'b0, 1'b0, 8'd0,   1'b0, 8'h00, 8'h20, 8'h20}, // R6
        {1'b0, 1'b0, 8'd0,   1'b0, 8'h00, 8'h00, 8'h00}, // R7 clear core 5
        {1'b1, 1'b0, 8'd7,   1'b0, 8'hFF, 8'hFF, 8'h80}, // R8 wake during power-down
        {1'b1, 1'b0, 8'd0,   1'b0, 8'hFF, 8'hFF, 8'h81}, // R10 second core
        {1'b0, 1'b0, 8'd0,   1'b0, 8'hFF, 8'h00, 8'h81}, // R8 fall with sleep set
        {1'b1, 1'b1, 8'd0,   1'b1, 8'hFF, 8'h00, 8'h81}, // R4 repeat set
        {1'b0, 1'b0, 8'd0,   1'b0, 8'h00, 8'hFF, 8'h81}, // R6
        {1'b0, 1'b0, 8'd0,   1'b0, 8'h00, 8'h7F, 8'h01}, // R7/R10 clear core 7 only
        {1'b0, 1'b0, 8'd0,   1'b0, 8'h00, 8'h7E, 8'h00}  // R7 clear core 0
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          s_tvalid = 1'b0;
    logic          s_tready;
    logic [IW:0]   s_tdata = '0;
    logic          oneofn_en = 1'b0;
    logic [NC-1:0] proc_sleep = '0;
    logic [NC-1:0] kids_asleep = '0;
    logic [NC-1:0] wake_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    wake_req_gen #(.NUM_CORES(NC), .IDX_W(IW)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_tvalid   (s_tvalid),
        .s_tready   (s_tready),
        .s_tdata    (s_tdata),
        .oneofn_en  (oneofn_en),
        .proc_sleep (proc_sleep),
        .kids_asleep(kids_asleep),
        .wake_req   (wake_req)
    );

    task automatic check(input string req, input logic [NC-1:0] act, input logic [NC-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply inputs after a falling edge; the edge in between captures them.
    task automatic drive(input logic v, input logic k, input logic [7:0] idx, input logic en,
                         input logic [NC-1:0] ps, input logic [NC-1:0] ka);
        s_tvalid    = v;
        s_tdata     = {k, idx};
        oneofn_en   = en;
        proc_sleep  = ps;
        kids_asleep = ka;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", wake_req, '0);
        check("R2 ready high", {7'b0, s_tready}, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);

        for (int r = 0; r < NV; r++) begin
            drive(VEC[r][34], VEC[r][33], VEC[r][32:25], VEC[r][24], VEC[r][23:16], VEC[r][15:8]);
            @(negedge clk);
            check($sformatf("table row %0d", r), wake_req, VEC[r][7:0]);
        end

        // R1: reset wipes set bits and edge history.
        drive(1'b1, 1'b0, 8'd3, 1'b0, 8'h00, 8'hFF);
        @(negedge clk);
        check("R3 set core 3", wake_req, 8'h08);
        drive(1'b0, 1'b0, 8'd0, 1'b0, 8'h00, 8'hFF);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears", wake_req, 8'h00);
        rst_n = 1'b1;
        drive(1'b1, 1'b0, 8'd6, 1'b0, 8'h00, 8'h00);
        @(negedge clk);
        check("R1 R3 set after reset", wake_req, 8'h40);
        drive(1'b0, 1'b0, 8'd0, 1'b0, 8'h00, 8'h00);
        @(negedge clk);
        check("R6 held with asleep low", wake_req, 8'h40);

        // R5: the highest index value.
        drive(1'b1, 1'b1, 8'd255, 1'b1, 8'h00, 8'h00);
        @(negedge clk);
        check("R5 index 255", wake_req, 8'h40);
        // R4: highest legal core via 1-of-N.
        drive(1'b1, 1'b1, 8'd7, 1'b1, 8'h00, 8'h00);
        @(negedge clk);
        check("R4 1-of-N core 7", wake_req, 8'hC0);
        drive(1'b0, 1'b0, 8'd0, 1'b0, 8'h00, 8'h00);
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule